// File: doc/BRIEF.md
# Multi-Cycle Register-Transfer Add Core

This block is a small sequential processor. It executes a stream of fixed-length 32-bit register-register add instructions, one at a time. Each instruction goes through four phases in a fixed order: fetch, decode, execute and writeback.

- **Fetch** reads four bytes from a byte-wide instruction memory port. The memory answers one cycle after it is given an address. The bytes are assembled little-endian into an instruction word, and the program counter moves forward by four.
- **Decode** completes the instruction word.
- **Execute** reads the two source registers from a 32-entry file and forms their sum.
- **Writeback** stores the sum into the destination register and updates a zero flag.

The instruction word is split into fields as follows. The top six bits are the operation code. Below them are three 5-bit register numbers, in this order: destination, first source, second source. The lowest eleven bits are not used. The only accepted operation code is all zeros. Any other code stops the core and raises a flag that stays set until reset.

A debug port reads any register at any time. The same port can also write a register. While a debug write is pending, the sequencer holds in its current phase. This is how a test environment loads operand values, because reset clears every register and adds alone can never create a non-zero value.

Top module: `addcore_top`

## Requirements
- R1: While reset is low, and after it is released, the program counter equals the start address (default 0x1000). All 32 registers read zero. The zero flag, the illegal flag and the retire pulse are low. The core begins in the first fetch cycle.
- R2: An instruction word is assembled from four consecutive bytes, with the byte at the lowest address as the least significant byte. For example, the bytes 00 10 61 00 form 0x00611000, which is add r3, r1, r2.
- R3: In the four fetch cycles of an instruction, the memory address is PC, PC+1, PC+2 and PC+3 on consecutive cycles. The byte for each address is taken one cycle after the address is presented.
- R4: The program counter changes only by +4, once per fetched instruction, in the last fetch cycle.
- R5: When no debug write is pending, an instruction takes exactly 7 cycles: 4 fetch, 1 decode, 1 execute and 1 writeback. `retire` is high for one cycle, in writeback.
- R6: Writeback stores (rs1 + rs2) mod 2^32 into rd. rd is bits 25..21, rs1 is bits 20..16 and rs2 is bits 15..11. No other register changes.
- R7: An instruction that uses the previous destination register as a source reads the newly written value.
- R8: The zero flag is updated at each writeback. It is 1 exactly when the stored sum is zero.
- R9: An operation code (bits 31..26) other than 000000 sets `illegal`, and the flag stays set until reset. After that, no register is written, there are no further retire pulses, and the program counter and zero flag hold their values.
- R10: Register r0 is an ordinary register: it can be written and reads back the written value.
- R11: Bits 10..0 of the instruction word have no effect on the result.
- R12: When `dbg_we` is high, `dbg_wdata` is written into register `dbg_sel` at the clock edge, and the sequencer holds in its current phase for that cycle. `dbg_rdata` always shows the register selected by `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address to instruction memory |
| imem_rdata | input | 8 | Byte returned one cycle after its address |
| dbg_sel | input | 5 | Register index for debug read and write |
| dbg_we | input | 1 | Debug write strobe; holds the sequencer |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Contents of register `dbg_sel` |
| pc | output | 32 | Program counter |
| zero_flag | output | 1 | Last written sum was zero |
| illegal | output | 1 | Sticky illegal-opcode flag; core halted |
| retire | output | 1 | One-cycle pulse in writeback |

## Verification
The assertions check, on every cycle, the rules that only concern timing and sequencing:
- the program counter only ever steps by four;
- exactly seven unstalled cycles separate consecutive retire pulses;
- a pending debug write freezes the program counter and suppresses retirement;
- the zero flag follows the written sum;
- the illegal flag never clears, and while it is set the core stays silent.

Some behaviours can only be shown by the bench's scenarios. These are: little-endian byte assembly, the field positions, the modulo-2^32 sums, the dependent read of a just-written register, the use of r0 as an ordinary destination, and the fact that the low instruction bits are ignored. Each of these depends on the program loaded into memory and on the register values read back through the debug port.

// File: rtl/addcore_pkg.sv
package addcore_pkg;
  localparam int XLEN  = 32;
  localparam int ILEN  = 32;
  localparam int NREG  = 32;
  localparam int RIDX  = $clog2(NREG);
  localparam int OPW   = 6;
  localparam int BYTES = ILEN / 8;
  localparam int BCW   = $clog2(BYTES);

  localparam logic [OPW-1:0] OP_ADD = '0;

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_DECODE,
    PH_EXEC,
    PH_WB,
    PH_HALT
  } phase_t;

  function automatic logic [OPW-1:0] f_opcode(input logic [ILEN-1:0] w);
    return w[ILEN-1 -: OPW];
  endfunction

  function automatic logic [RIDX-1:0] f_rd(input logic [ILEN-1:0] w);
    return w[ILEN-OPW-1 -: RIDX];
  endfunction

  function automatic logic [RIDX-1:0] f_rs1(input logic [ILEN-1:0] w);
    return w[ILEN-OPW-RIDX-1 -: RIDX];
  endfunction

  function automatic logic [RIDX-1:0] f_rs2(input logic [ILEN-1:0] w);
    return w[ILEN-OPW-2*RIDX-1 -: RIDX];
  endfunction

  function automatic logic [XLEN-1:0] f_sum(input logic [XLEN-1:0] a,
                                            input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  function automatic logic f_is_zero(input logic [XLEN-1:0] v);
    return v == '0;
  endfunction
endpackage

// File: rtl/addcore_fetch.sv
module addcore_fetch
  import addcore_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] START = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            in_fetch,
  input  logic [7:0]      imem_rdata,
  output logic [AW-1:0]   imem_addr,
  output logic [AW-1:0]   pc,
  output logic [ILEN-1:0] ir,
  output logic            fetch_last
);
  logic [BCW-1:0] bcnt;
  logic           pend_v;
  logic [BCW-1:0] pend_lane;
  logic           issue;

  assign issue      = in_fetch && advance;
  assign fetch_last = (bcnt == BCW'(BYTES - 1));
  assign imem_addr  = pc + AW'(bcnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt      <= '0;
      pc        <= START;
      pend_v    <= 1'b0;
      pend_lane <= '0;
    end else begin
      pend_v    <= issue;
      pend_lane <= bcnt;
      if (issue) begin
        bcnt <= bcnt + 1'b1;
        if (fetch_last) pc <= pc + AW'(BYTES);
      end
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ir[8*g +: 8] <= '0;
      else if (pend_v && pend_lane == BCW'(g))
        ir[8*g +: 8] <= imem_rdata;
    end
  end
endmodule

// File: rtl/addcore_regfile.sv
module addcore_regfile
  import addcore_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIDX-1:0] ra1,
  input  logic [RIDX-1:0] ra2,
  input  logic [RIDX-1:0] ra3,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  output logic [XLEN-1:0] rd3,
  input  logic            we,
  input  logic [RIDX-1:0] wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (we && wa == RIDX'(i))
        regs[i] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
  assign rd3 = regs[ra3];
endmodule

// File: rtl/addcore_ctrl.sv
module addcore_ctrl
  import addcore_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           fetch_last,
  input  logic [OPW-1:0] opcode,
  output phase_t         phase,
  output logic           advance,
  output logic           wb_en,
  output logic           illegal
);
  phase_t nxt;

  assign advance = !hold && (phase != PH_HALT);
  assign wb_en   = advance && (phase == PH_WB);

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_FETCH:  if (fetch_last) nxt = PH_DECODE;
      PH_DECODE: nxt = PH_EXEC;
      PH_EXEC:   nxt = (opcode == OP_ADD) ? PH_WB : PH_HALT;
      PH_WB:     nxt = PH_FETCH;
      default:   nxt = PH_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_FETCH;
      illegal <= 1'b0;
    end else if (advance) begin
      phase <= nxt;
      if (phase == PH_EXEC && opcode != OP_ADD) illegal <= 1'b1;
    end
  end
endmodule

// File: rtl/addcore_top.sv
module addcore_top
  import addcore_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] START = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [AW-1:0]   imem_addr,
  input  logic [7:0]      imem_rdata,
  input  logic [RIDX-1:0] dbg_sel,
  input  logic            dbg_we,
  input  logic [XLEN-1:0] dbg_wdata,
  output logic [XLEN-1:0] dbg_rdata,
  output logic [AW-1:0]   pc,
  output logic            zero_flag,
  output logic            illegal,
  output logic            retire
);
  phase_t          phase;
  logic            advance;
  logic            wb_en;
  logic            fetch_last;
  logic [ILEN-1:0] ir;
  logic [XLEN-1:0] op_a, op_b;
  logic [XLEN-1:0] wb_data;
  logic            rf_we;
  logic [RIDX-1:0] rf_wa;
  logic [XLEN-1:0] rf_wd;

  addcore_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (dbg_we),
    .fetch_last(fetch_last),
    .opcode    (f_opcode(ir)),
    .phase     (phase),
    .advance   (advance),
    .wb_en     (wb_en),
    .illegal   (illegal)
  );

  addcore_fetch #(.AW(AW), .START(START)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .in_fetch  (phase == PH_FETCH),
    .imem_rdata(imem_rdata),
    .imem_addr (imem_addr),
    .pc        (pc),
    .ir        (ir),
    .fetch_last(fetch_last)
  );

  assign rf_we = wb_en || dbg_we;
  assign rf_wa = wb_en ? f_rd(ir) : dbg_sel;
  assign rf_wd = wb_en ? wb_data : dbg_wdata;

  addcore_regfile u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .ra1  (f_rs1(ir)),
    .ra2  (f_rs2(ir)),
    .ra3  (dbg_sel),
    .rd1  (op_a),
    .rd2  (op_b),
    .rd3  (dbg_rdata),
    .we   (rf_we),
    .wa   (rf_wa),
    .wd   (rf_wd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_data   <= '0;
      zero_flag <= 1'b0;
    end else begin
      if (advance && phase == PH_EXEC) wb_data <= f_sum(op_a, op_b);
      if (wb_en) zero_flag <= f_is_zero(wb_data);
    end
  end

  assign retire = wb_en;
endmodule

// File: rtl/addcore_chk.sv
module addcore_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pc,
  input logic          retire,
  input logic          illegal,
  input logic          zero_flag,
  input logic          dbg_we,
  input logic [31:0]   wb_data
);
  logic [3:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else if (retire) gap <= '0;
    else if (!dbg_we && gap != 4'hF) gap <= gap + 1'b1;
  end

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> (pc == $past(pc) + AW'(4)));

  // R5
  retire_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (gap == 4'd6));

  // R12
  dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_we |=> $stable(pc));

  // R12
  dbg_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_we |-> !retire);

  // R8
  zero_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (zero_flag == ($past(wb_data) == 32'd0)));

  // R9
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !retire);

  // R9
  illegal_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> ($stable(pc) && $stable(zero_flag)));
endmodule

bind addcore_top addcore_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pc       (pc),
  .retire   (retire),
  .illegal  (illegal),
  .zero_flag(zero_flag),
  .dbg_we   (dbg_we),
  .wb_data  (wb_data)
);

// File: tb/test_addcore_top.sv
module test_addcore_top;
  localparam logic [31:0] START = 32'h0000_1000;
  localparam int NV = 9;

  // fields: opcode[31:26] rd[25:21] rs1[20:16] rs2[15:11] low[10:0]
  localparam logic [31:0] VEC [NV+1] = '{
    {6'd0, 5'd3,  5'd1, 5'd2, 11'd0},      // R2 R6: 7+11
    {6'd0, 5'd4,  5'd3, 5'd3, 11'd0},      // R7 dependent on r3
    {6'd0, 5'd10, 5'd5, 5'd6, 11'd0},      // R6 R8 wrap to zero
    {6'd0, 5'd11, 5'd7, 5'd7, 11'd0},      // R8 wrap to zero
    {6'd0, 5'd12, 5'd8, 5'd9, 11'd0},      // R6 general sum
    {6'd0, 5'd0,  5'd1, 5'd1, 11'd0},      // R10 write r0
    {6'd0, 5'd13, 5'd0, 5'd2, 11'd0},      // R10 read r0
    {6'd0, 5'd5,  5'd5, 5'd5, 11'd0},      // R6 rd equals rs
    {6'd0, 5'd14, 5'd1, 5'd2, 11'h7FF},    // R11 low bits set
    {6'h3F, 5'd15, 5'd1, 5'd2, 11'd0}      // R9 illegal opcode
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr;
  logic [7:0]  imem_rdata;
  logic [4:0]  dbg_sel = '0;
  logic        dbg_we = 1'b0;
  logic [31:0] dbg_wdata = '0;
  logic [31:0] dbg_rdata;
  logic [31:0] pc;
  logic        zero_flag, illegal, retire;

  logic [7:0]  mem [256];
  logic [31:0] model [32];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) imem_rdata <= mem[imem_addr[7:0]];

  addcore_top i_addcore_top (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dbg_sel(dbg_sel), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .pc(pc), .zero_flag(zero_flag),
    .illegal(illegal), .retire(retire)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input int idx, output logic [31:0] v);
    dbg_sel = 5'(idx);
    #1 v = dbg_rdata;
  endtask

  task automatic dbg_write(input int idx, input logic [31:0] v);
    dbg_sel = 5'(idx);
    dbg_wdata = v;
    dbg_we = 1'b1;
    @(negedge clk);
    dbg_we = 1'b0;
    model[idx] = v;
  endtask

  task automatic check_reset();
    logic [31:0] v;
    chk("R1 pc", pc, START);
    chk("R1 illegal", 32'(illegal), 0);
    chk("R1 zero", 32'(zero_flag), 0);
    chk("R1 retire", 32'(retire), 0);
    for (int i = 0; i < 32; i++) begin
      rd_reg(i, v);
      chk("R1 reg clear", v, 0);
    end
  endtask

  initial begin
    logic [31:0] v, w, s;
    int gap;
    int rets;
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    for (int i = 0; i <= NV; i++)
      for (int b = 0; b < 4; b++)
        mem[8'(START) + 8'(4*i + b)] = VEC[i][8*b +: 8];  // R2 little-endian
    for (int i = 0; i < 32; i++) model[i] = 0;

    repeat (4) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    // R3: addresses PC..PC+3 in the four fetch cycles
    for (int b = 0; b < 4; b++) begin
      #1 chk("R3 fetch address", imem_addr, START + 32'(b));
      @(negedge clk);
    end
    #1 chk("R4 pc after fetch", pc, START + 4);

    // R12: preload operands while the sequencer is held in decode
    dbg_write(1, 32'h0000_0007);
    dbg_write(2, 32'h0000_000B);
    dbg_write(5, 32'hFFFF_FFFF);
    dbg_write(6, 32'h0000_0001);
    dbg_write(7, 32'h8000_0000);
    dbg_write(8, 32'h1234_5678);
    dbg_write(9, 32'h0F0F_0F0F);
    chk("R12 pc held", pc, START + 4);
    chk("R12 no retire while held", 32'(retire), 0);
    rd_reg(8, v);
    chk("R12 debug readback", v, 32'h1234_5678);

    // walk the vector table
    for (int i = 0; i < NV; i++) begin
      w = VEC[i];
      gap = 1;
      while (!retire && gap < 40) begin
        @(negedge clk);
        #1 gap++;
      end
      if (i > 0) chk("R5 cycles per instruction", 32'(gap), 7);
      s = model[w[20:16]] + model[w[15:11]];   // R6 modulo 2^32
      model[w[25:21]] = s;
      @(negedge clk);
      rd_reg(int'(w[25:21]), v);
      chk($sformatf("R6 R7 result vector %0d", i), v, s);
      chk("R8 zero flag", 32'(zero_flag), 32'(s == 0));
      chk("R4 pc", pc, START + 32'(4 * (i + 1)));
      #1;
    end
    chk("R2 first instruction word result", model[3], 32'h12);
    chk("R10 r0 holds written value", model[0], 32'd14);

    // R9: illegal opcode halts with no further effect
    rets = 0;
    repeat (25) begin
      @(negedge clk);
      if (retire) rets++;
    end
    chk("R9 no retire after illegal", 32'(rets), 0);
    chk("R9 illegal set", 32'(illegal), 1);
    chk("R9 pc frozen", pc, START + 32'(4 * (NV + 1)));
    chk("R9 zero flag kept", 32'(zero_flag), 0);
    for (int i = 0; i < 32; i++) begin
      rd_reg(i, v);
      chk($sformatf("R6 R9 final reg %0d", i), v, model[i]);
    end
    repeat (5) @(negedge clk);
    chk("R9 illegal sticky", 32'(illegal), 1);

    rst_n = 1'b0;
    #1 check_reset();
    rst_n = 1'b1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule